// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes in asynchronous smart card characters on one serial data line. It is clocked by a basic clock that runs at a selectable multiple of the bit rate: 32, 64, 372 or 256 clocks per bit. The falling edge of the start bit aligns the block's internal bit timing. Each later bit is then sampled once, at its centre. A character has ten bits: a start bit, eight data bits and a parity bit.

The receiver can decode both bit orders and can invert the data bits for the inverse convention. It checks parity against a selectable sense. It reports the byte with a one-clock valid strobe and keeps a sticky parity error flag. In normal mode a parity error also produces a one-clock error-signal pulse and sets a sticky error-signal status. In block transfer mode the parity flag still works, but the error-signal pulse and its status stay low. Software must clear the parity flag before the parity bit of the next character arrives.

Top module: `sc_char_rx`

## Requirements
- R1: `ratio_sel` picks the clocks per bit: 0 selects 32, 1 selects 64, 2 selects 372 and 3 selects 256. Characters are received correctly at every ratio.
- R2: The line is synchronised, and the falling edge of the start bit starts the bit timing. Each bit is sampled N/2 clocks into the bit, so a bit value that is valid only in the middle half of its bit time is still received correctly.
- R3: If the line is high again when the middle of the start bit is sampled, the edge is treated as a glitch. The receiver returns to idle and produces no strobe.
- R4: A character is a low start bit, eight data bits and one parity bit. `rx_valid` goes high for exactly one clock per character, after the parity bit has been sampled, and `rx_byte` holds the byte in that cycle.
- R5: With `msb_first`=0 the first data bit is bit 0 of the byte. With `msb_first`=1 the first data bit is bit 7.
- R6: With `data_invert`=1 each of the eight data bits is the inverse of the line level. The parity bit is never inverted.
- R7: A parity error occurs when the XOR of the eight decoded data bits and the raw parity bit differs from `parity_odd` (0 means even parity).
- R8: Take `msb_first`=`data_invert`=`parity_odd`=1 and, after the start bit, the line levels high, high, six lows and then a high parity bit. This start character decodes to 0x3F with no parity error.
- R9: In normal mode (`block_mode`=0) a parity error raises `err_pulse` for one clock, in the same cycle as `rx_valid`, and sets the sticky `err_sig_flag`.
- R10: In block mode (`block_mode`=1) a parity error sets `parity_err`, but `err_pulse` stays 0 and `err_sig_flag` stays 0.
- R11: `parity_err` and `err_sig_flag` stay set until `err_clear`. When a new error and `err_clear` fall in the same cycle, the new error wins.
- R12: After reset `rx_valid`, `rx_byte`, `parity_err`, `err_pulse` and `err_sig_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock, a multiple of the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rxd_in | input | 1 | Serial data line, idle high |
| ratio_sel | input | 2 | Clocks-per-bit select |
| msb_first | input | 1 | 1 = data arrives MSB first |
| data_invert | input | 1 | 1 = invert the eight data bits |
| parity_odd | input | 1 | 1 = expect odd parity |
| block_mode | input | 1 | 1 = block transfer mode, no error signal |
| err_clear | input | 1 | Clears the sticky flags |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-clock strobe per character |
| parity_err | output | 1 | Sticky parity error flag |
| err_pulse | output | 1 | One-clock error-signal pulse (normal mode) |
| err_sig_flag | output | 1 | Sticky error-signal status |

## Verification
The sticky flags can be set by a new parity error and cleared by `err_clear` in the same clock. The bench holds `err_clear` high for the whole of a character with bad parity, so both events land on the edge that raises `rx_valid`. In that valid cycle both `parity_err` and `err_sig_flag` must read 1. One clock later, with the clear still held, both must read 0.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  localparam int RATIO_W    = 2;
  localparam int CNT_W      = 9;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS
  } rx_state_e;

  function automatic logic [CNT_W-1:0] clocks_per_bit(input logic [RATIO_W-1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'd0:    n = CNT_W'(32);
      2'd1:    n = CNT_W'(64);
      2'd2:    n = CNT_W'(372);
      default: n = CNT_W'(256);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sc_rx_linesync.sv
module sc_rx_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], line_in};
      prev <= pipe[STAGES-1];
    end
  end

  assign line_s = pipe[STAGES-1];
  assign fall   = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/sc_rx_bittimer.sv
module sc_rx_bittimer
  import sc_rx_pkg::*;
#(
  parameter int CW    = CNT_W,
  parameter int NBITS = FRAME_BITS,
  parameter int IW    = $clog2(NBITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line,
  input  logic               fall,
  input  logic [RATIO_W-1:0] ratio_sel,
  output logic               smp_stb,
  output logic [IW-1:0]      smp_idx,
  output logic               smp_val
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);

  rx_state_e      state;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  len;
  logic [IW-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      len     <= '0;
      idx     <= '0;
      smp_stb <= 1'b0;
      smp_idx <= '0;
      smp_val <= 1'b1;
    end else begin
      smp_stb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_START;
            cnt   <= CW'(1);
            len   <= clocks_per_bit(ratio_sel);
            idx   <= '0;
          end
        end
        ST_START: begin
          if (cnt == (len >> 1)) begin
            if (line) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_BITS;
              cnt   <= CW'(1);
              idx   <= IW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_BITS: begin
          if (cnt == len) begin
            smp_stb <= 1'b1;
            smp_idx <= idx;
            smp_val <= line;
            cnt     <= CW'(1);
            if (idx == LAST_IDX) state <= ST_IDLE;
            else                 idx   <= idx + IW'(1);
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_rx_assemble.sv
module sc_rx_assemble #(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_stb,
  input  logic [IW-1:0] smp_idx,
  input  logic          smp_val,
  input  logic          msb_first,
  input  logic          data_invert,
  input  logic          parity_odd,
  input  logic          block_mode,
  input  logic          err_clear,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          parity_err,
  output logic          err_pulse,
  output logic          err_sig_flag
);
  localparam logic [IW-1:0] PAR_IDX = IW'(DW + 1);

  logic [DW-1:0] shreg;
  logic [DW-1:0] decoded;
  logic          dat_hit;
  logic          par_hit;
  logic          bad_now;

  always_comb begin
    dat_hit = smp_stb && (smp_idx != '0) && (smp_idx < PAR_IDX);
    par_hit = smp_stb && (smp_idx == PAR_IDX);
    decoded = shreg ^ {DW{data_invert}};
    bad_now = ((^decoded) ^ smp_val) != parity_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg        <= '0;
      rx_byte      <= '0;
      rx_valid     <= 1'b0;
      parity_err   <= 1'b0;
      err_pulse    <= 1'b0;
      err_sig_flag <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      err_pulse <= 1'b0;
      if (dat_hit) begin
        if (msb_first) shreg <= {shreg[DW-2:0], smp_val};
        else           shreg <= {smp_val, shreg[DW-1:1]};
      end
      if (par_hit) begin
        rx_byte   <= decoded;
        rx_valid  <= 1'b1;
        err_pulse <= bad_now & ~block_mode;
      end
      if (par_hit && bad_now)  parity_err <= 1'b1;
      else if (err_clear)      parity_err <= 1'b0;
      if (par_hit && bad_now && !block_mode) err_sig_flag <= 1'b1;
      else if (err_clear)                    err_sig_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxd_in,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic               msb_first,
  input  logic               data_invert,
  input  logic               parity_odd,
  input  logic               block_mode,
  input  logic               err_clear,
  output logic [DATA_W-1:0]  rx_byte,
  output logic               rx_valid,
  output logic               parity_err,
  output logic               err_pulse,
  output logic               err_sig_flag
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic             line_s;
  logic             fall;
  logic             smp_stb;
  logic [IDX_W-1:0] smp_idx;
  logic             smp_val;

  sc_rx_linesync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .line_in(rxd_in), .line_s(line_s), .fall(fall)
  );

  sc_rx_bittimer #(.CW(CNT_W), .NBITS(FRAME_BITS), .IW(IDX_W)) timer_i (
    .clk(clk), .rst(rst), .line(line_s), .fall(fall), .ratio_sel(ratio_sel),
    .smp_stb(smp_stb), .smp_idx(smp_idx), .smp_val(smp_val)
  );

  sc_rx_assemble #(.DW(DATA_W), .IW(IDX_W)) asm_i (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_idx(smp_idx), .smp_val(smp_val),
    .msb_first(msb_first), .data_invert(data_invert), .parity_odd(parity_odd),
    .block_mode(block_mode), .err_clear(err_clear),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .parity_err(parity_err),
    .err_pulse(err_pulse), .err_sig_flag(err_sig_flag)
  );
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk (
  input logic clk,
  input logic rst,
  input logic block_mode,
  input logic err_clear,
  input logic rx_valid,
  input logic parity_err,
  input logic err_pulse,
  input logic err_sig_flag
);
  // R4: the strobe is one clock wide
  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9: the error pulse comes only with a strobe and a set parity flag
  a_r9_pulse_with_valid: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (rx_valid && parity_err && err_sig_flag));

  // R10: no error pulse when block mode was selected
  a_r10_block_no_pulse: assert property (@(posedge clk) disable iff (rst)
    $past(block_mode) |-> !err_pulse);

  // R11: flags hold until cleared
  a_r11_parity_sticky: assert property (@(posedge clk) disable iff (rst)
    (parity_err && !err_clear) |=> parity_err);

  a_r11_sig_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_sig_flag && !err_clear) |=> err_sig_flag);

  // R11: the parity flag rises only with a character strobe
  a_r11_rise_on_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(parity_err) |-> rx_valid);

  // R12: reset clears the outputs
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (!rx_valid && !parity_err && !err_pulse && !err_sig_flag));
endmodule

bind sc_char_rx sc_char_rx_chk chk_i (
  .clk(clk), .rst(rst), .block_mode(block_mode), .err_clear(err_clear),
  .rx_valid(rx_valid), .parity_err(parity_err), .err_pulse(err_pulse),
  .err_sig_flag(err_sig_flag)
);

// File: tb/sc_char_rx_tb_top.sv
module sc_char_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd_in = 1'b1;
  logic [1:0] ratio_sel = 2'd0;
  logic       msb_first = 1'b0;
  logic       data_invert = 1'b0;
  logic       parity_odd = 1'b0;
  logic       block_mode = 1'b0;
  logic       err_clear = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid, parity_err, err_pulse, err_sig_flag;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tot_valid = 0;
  int tot_pulse = 0;
  logic [7:0] cap_byte = '0;
  logic cap_perr = 1'b0, cap_pulse = 1'b0, cap_flag = 1'b0;

  always #10 clk = ~clk;

  sc_char_rx dut_i (
    .clk(clk), .rst(rst), .rxd_in(rxd_in), .ratio_sel(ratio_sel),
    .msb_first(msb_first), .data_invert(data_invert), .parity_odd(parity_odd),
    .block_mode(block_mode), .err_clear(err_clear),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .parity_err(parity_err),
    .err_pulse(err_pulse), .err_sig_flag(err_sig_flag)
  );

  // {ratio[14:13], msb[12], inv[11], podd[10], blk[9], bad[8], byte[7:0]}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hE7},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF}
  };

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      tot_valid = tot_valid + 1;
      cap_byte  = rx_byte;
      cap_perr  = parity_err;
      cap_pulse = err_pulse;
      cap_flag  = err_sig_flag;
    end
    if (!rst && err_pulse) tot_pulse = tot_pulse + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc >= 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int clocks(input logic [1:0] r);
    case (r)
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 372;
      default: return 256;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bits[0] is the start bit, bits[9] the parity bit, in line order
  task automatic send_raw(input logic [1:0] r, input logic [9:0] bits, input bit center);
    int n;
    n = clocks(r);
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < n; c++) begin
        @(negedge clk);
        if (center && k >= 1 && k <= 8 && (c < n / 4 || c >= 3 * n / 4))
          rxd_in = ~bits[k];
        else
          rxd_in = bits[k];
      end
    end
    @(negedge clk);
    rxd_in = 1'b1;
    repeat (2 * n) @(negedge clk);
  endtask

  function automatic logic [9:0] build(input logic m, input logic inv, input logic podd,
                                       input logic bad, input logic [7:0] b);
    logic [9:0] bits;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      bits[1 + i] = (m ? b[7 - i] : b[i]) ^ inv;
    bits[9] = (^b) ^ podd ^ bad;
    return bits;
  endfunction

  task automatic clear_flags();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int v0;
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(rx_valid == 0 && rx_byte == 0, "R12 valid/byte after reset", {rx_valid, rx_byte}, 0);
    chk(parity_err == 0 && err_pulse == 0 && err_sig_flag == 0, "R12 flags after reset",
        {parity_err, err_pulse, err_sig_flag}, 0);

    // Vector loop: R1 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      logic exp_pulse;
      v = VEC[i];
      ratio_sel = v[14:13]; msb_first = v[12]; data_invert = v[11];
      parity_odd = v[10]; block_mode = v[9];
      exp_pulse = v[8] & ~v[9];
      v0 = tot_valid; p0 = tot_pulse;
      send_raw(v[14:13], build(v[12], v[11], v[10], v[8], v[7:0]), 1'b0);
      chk(tot_valid - v0 == 1, "R4 one-clock strobe per character", tot_valid - v0, 1);
      chk(cap_byte == v[7:0], "R1/R5/R6 received byte", cap_byte, v[7:0]);
      chk(cap_perr == v[8], "R7 parity error flag", cap_perr, v[8]);
      chk(cap_pulse == exp_pulse && tot_pulse - p0 == int'(exp_pulse),
          "R9/R10 error pulse", tot_pulse - p0, exp_pulse);
      chk(cap_flag == exp_pulse, "R9/R10 error-signal status", cap_flag, exp_pulse);
      if (v[8]) begin
        @(negedge clk);
        chk(parity_err == 1'b1, "R11 flag sticky before clear", parity_err, 1);
      end
      clear_flags();
      chk(parity_err == 0 && err_sig_flag == 0, "R11 flags cleared",
          {parity_err, err_sig_flag}, 0);
    end
    block_mode = 1'b0;

    // R3: start glitch shorter than half a bit
    ratio_sel = 2'd0; msb_first = 1'b0; data_invert = 1'b0; parity_odd = 1'b0;
    v0 = tot_valid;
    @(negedge clk); rxd_in = 1'b0;
    repeat (8) @(negedge clk);
    rxd_in = 1'b1;
    repeat (12 * 32) @(negedge clk);
    chk(tot_valid == v0, "R3 glitch gives no strobe", tot_valid - v0, 0);
    send_raw(2'd0, build(1'b0, 1'b0, 1'b0, 1'b0, 8'h6B), 1'b0);
    chk(tot_valid - v0 == 1 && cap_byte == 8'h6B, "R3 receive after glitch", cap_byte, 8'h6B);

    // R2: data valid only in the middle half of each bit
    ratio_sel = 2'd1;
    v0 = tot_valid;
    send_raw(2'd1, build(1'b0, 1'b0, 1'b0, 1'b0, 8'hC6), 1'b1);
    chk(tot_valid - v0 == 1 && cap_byte == 8'hC6, "R2 centre sampling", cap_byte, 8'hC6);
    chk(cap_perr == 1'b0, "R2 centre sampling parity", cap_perr, 0);

    // R8: inverse convention start character
    ratio_sel = 2'd0; msb_first = 1'b1; data_invert = 1'b1; parity_odd = 1'b1;
    v0 = tot_valid;
    send_raw(2'd0, 10'b1_000000_11_0, 1'b0);
    chk(tot_valid - v0 == 1 && cap_byte == 8'h3F, "R8 start character byte", cap_byte, 8'h3F);
    chk(cap_perr == 1'b0, "R8 start character parity", cap_perr, 0);
    clear_flags();

    // R11: error and clear in the same cycle, new error wins
    msb_first = 1'b0; data_invert = 1'b0; parity_odd = 1'b0; block_mode = 1'b0;
    @(negedge clk); err_clear = 1'b1;
    send_raw(2'd0, build(1'b0, 1'b0, 1'b0, 1'b1, 8'h99), 1'b0);
    chk(cap_perr == 1'b1, "R11 set wins over clear (parity)", cap_perr, 1);
    chk(cap_flag == 1'b1, "R11 set wins over clear (status)", cap_flag, 1);
    chk(parity_err == 0 && err_sig_flag == 0, "R11 clear held afterwards",
        {parity_err, err_sig_flag}, 0);
    err_clear = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule